// File: doc/BRIEF.md
# Snapshot capture and display controller

This block moves whole video frames on request. A rising edge on the capture button copies the frame held in the live frame buffer, pixel by pixel, into an external snapshot store. A rising edge on the show button reads the stored frame back and writes it into a second on-chip frame buffer that feeds the display path. Each transfer visits every pixel address once, starting at zero and counting up in raster order. It ends with a one-cycle done pulse.

The block also drives the select line of the video output multiplexer. The select picks the snapshot buffer only while the show button is held and goes back to live video when the button is released. While a capture copy is running, the block asserts a freeze line so that the camera writer leaves the live buffer alone and the captured image is not torn. The store port is a synchronous memory port with a ready handshake. Read data from the store comes back one cycle after the read request is accepted. The frame size is set by parameters; the default is 320 by 240 pixels.

Top module: `snapcap_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after it, st_req, live_rd_en, snap_wr_en, live_freeze, disp_sel, take_done and show_done are all 0.
- R2: disp_sel is a registered copy of the show button level: it equals btn_show as sampled at the previous clock edge (1 = snapshot buffer, 0 = live video).
- R3: A rising edge of btn_take while idle copies the live buffer into the store. Every address from 0 to H_PIX*V_PIX-1 is visited in increasing order. Live buffer reads have one cycle of latency, and each word is written to the store at the address it was read from.
- R4: While st_req is high and st_ready is low, the request is held on the next cycle with the same st_addr, st_we and (for writes) st_wdata. A pixel advances only on a cycle where st_req and st_ready are both high.
- R5: A rising edge of btn_show while idle copies the store into the snapshot buffer at the same addresses. The store read data is taken one cycle after the read is accepted.
- R6: Exactly one single-cycle done pulse (take_done for a capture, show_done for a show) is raised in the cycle after the last pixel completes. The two pulses are never high together.
- R7: live_freeze is high for the whole capture copy, including every store write. It is low during a show copy and while idle.
- R8: A button edge that arrives while a transfer is running is dropped. A button still held after its transfer ends does not start another transfer.
- R9: When both buttons rise in the same idle cycle, the capture starts and the show edge is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Buffer-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| btn_take | input | 1 | Debounced capture button level |
| btn_show | input | 1 | Debounced show button level |
| live_rd_en | output | 1 | Live buffer read strobe |
| live_rd_addr | output | AW | Live buffer read address |
| live_rd_data | input | PIX_W | Live buffer read data, one cycle after the strobe |
| live_freeze | output | 1 | Holds off camera writes to the live buffer |
| st_req | output | 1 | Store access request |
| st_we | output | 1 | Store write (1) or read (0) |
| st_addr | output | AW | Store address |
| st_wdata | output | PIX_W | Store write data |
| st_ready | input | 1 | Store accepts the request this cycle |
| st_rdata | input | PIX_W | Store read data, one cycle after acceptance |
| snap_wr_en | output | 1 | Snapshot buffer write strobe |
| snap_wr_addr | output | AW | Snapshot buffer write address |
| snap_wr_data | output | PIX_W | Snapshot buffer write data |
| disp_sel | output | 1 | Output multiplexer select, 1 = snapshot |
| take_done | output | 1 | Capture finished pulse |
| show_done | output | 1 | Show finished pulse |

## Verification
The assertions assume the store keeps to its handshake: a read accepted on one edge returns its word on st_rdata during the next cycle, and st_ready may drop at any time without notice. They also assume the buttons are clean levels that change only between edges. The bench models the store and both buffers as simple arrays with exactly that timing. It drives st_ready from a seeded random draw whose probability varies per round and includes always-ready and rarely-ready rounds. Button levels change only on falling clock edges.

// File: rtl/snapcap_pkg.sv
package snapcap_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE    = 3'd0,
    SQ_TK_RD   = 3'd1,
    SQ_TK_CAP  = 3'd2,
    SQ_TK_WR   = 3'd3,
    SQ_SH_RD   = 3'd4,
    SQ_SH_WAIT = 3'd5
  } sq_state_t;

  function automatic int unsigned frame_pixels(int unsigned h, int unsigned v);
    return h * v;
  endfunction

  // Capture states: the live buffer must not change while in any of them.
  function automatic logic in_capture(sq_state_t s);
    return (s == SQ_TK_RD) || (s == SQ_TK_CAP) || (s == SQ_TK_WR);
  endfunction

  // Show states.
  function automatic logic in_show(sq_state_t s);
    return (s == SQ_SH_RD) || (s == SQ_SH_WAIT);
  endfunction

endpackage

// File: rtl/snapcap_btn_edge.sv
module snapcap_btn_edge #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise
);

  logic [N-1:0] lvl_q;

  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q[g] <= 1'b0;
      else        lvl_q[g] <= lvl[g];
    end
    assign rise[g] = lvl[g] & ~lvl_q[g];
  end

endmodule

// File: rtl/snapcap_pix_walker.sv
module snapcap_pix_walker #(
  parameter int NPIX = 76800,
  parameter int AW   = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  output logic [AW-1:0] addr,
  output logic          last
);

  localparam logic [AW-1:0] LAST_ADDR = AW'(NPIX - 1);

  assign last = (addr == LAST_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      addr <= '0;
    else if (step)   addr <= last ? '0 : addr + 1'b1;
  end

endmodule

// File: rtl/snapcap_seq.sv
module snapcap_seq
  import snapcap_pkg::*;
#(
  parameter int PIX_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take_rise,
  input  logic             show_rise,
  input  logic             pix_last,
  input  logic             st_ready,
  input  logic [PIX_W-1:0] live_rd_data,
  input  logic [PIX_W-1:0] st_rdata,
  output logic             live_rd_en,
  output logic             live_freeze,
  output logic             st_req,
  output logic             st_we,
  output logic [PIX_W-1:0] st_wdata,
  output logic             snap_wr_en,
  output logic [PIX_W-1:0] snap_wr_data,
  output logic             pix_step,
  output logic             take_done,
  output logic             show_done
);

  sq_state_t        state, state_nx;
  logic [PIX_W-1:0] hold_q;
  logic             take_fin, show_fin;

  always_comb begin
    state_nx   = state;
    live_rd_en = 1'b0;
    st_req     = 1'b0;
    st_we      = 1'b0;
    snap_wr_en = 1'b0;
    pix_step   = 1'b0;
    take_fin   = 1'b0;
    show_fin   = 1'b0;
    unique case (state)
      SQ_IDLE: begin
        if (take_rise)      state_nx = SQ_TK_RD;
        else if (show_rise) state_nx = SQ_SH_RD;
      end
      SQ_TK_RD: begin
        live_rd_en = 1'b1;
        state_nx   = SQ_TK_CAP;
      end
      SQ_TK_CAP: state_nx = SQ_TK_WR;
      SQ_TK_WR: begin
        st_req = 1'b1;
        st_we  = 1'b1;
        if (st_ready) begin
          pix_step = 1'b1;
          take_fin = pix_last;
          state_nx = pix_last ? SQ_IDLE : SQ_TK_RD;
        end
      end
      SQ_SH_RD: begin
        st_req = 1'b1;
        if (st_ready) state_nx = SQ_SH_WAIT;
      end
      SQ_SH_WAIT: begin
        snap_wr_en = 1'b1;
        pix_step   = 1'b1;
        show_fin   = pix_last;
        state_nx   = pix_last ? SQ_IDLE : SQ_SH_RD;
      end
      default: state_nx = SQ_IDLE;
    endcase
  end

  assign live_freeze  = in_capture(state);
  assign st_wdata     = hold_q;
  assign snap_wr_data = st_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= SQ_IDLE;
      hold_q    <= '0;
      take_done <= 1'b0;
      show_done <= 1'b0;
    end else begin
      state     <= state_nx;
      take_done <= take_fin;
      show_done <= show_fin;
      if (state == SQ_TK_CAP) hold_q <= live_rd_data;
    end
  end

endmodule

// File: rtl/snapcap_ctrl.sv
module snapcap_ctrl
  import snapcap_pkg::*;
#(
  parameter  int H_PIX = 320,
  parameter  int V_PIX = 240,
  parameter  int PIX_W = 16,
  localparam int NPIX  = int'(frame_pixels(H_PIX, V_PIX)),
  localparam int AW    = $clog2(NPIX)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             btn_take,
  input  logic             btn_show,
  output logic             live_rd_en,
  output logic [AW-1:0]    live_rd_addr,
  input  logic [PIX_W-1:0] live_rd_data,
  output logic             live_freeze,
  output logic             st_req,
  output logic             st_we,
  output logic [AW-1:0]    st_addr,
  output logic [PIX_W-1:0] st_wdata,
  input  logic             st_ready,
  input  logic [PIX_W-1:0] st_rdata,
  output logic             snap_wr_en,
  output logic [AW-1:0]    snap_wr_addr,
  output logic [PIX_W-1:0] snap_wr_data,
  output logic             disp_sel,
  output logic             take_done,
  output logic             show_done
);

  logic [1:0]    btn_rise;
  logic          take_rise, show_rise;
  logic          pix_step, pix_last;
  logic [AW-1:0] pix_addr;

  snapcap_btn_edge #(.N(2)) u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .lvl  ({btn_show, btn_take}),
    .rise (btn_rise)
  );

  assign take_rise = btn_rise[0];
  assign show_rise = btn_rise[1];

  snapcap_pix_walker #(.NPIX(NPIX), .AW(AW)) u_walk (
    .clk  (clk),
    .rst_n(rst_n),
    .step (pix_step),
    .addr (pix_addr),
    .last (pix_last)
  );

  snapcap_seq #(.PIX_W(PIX_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .take_rise   (take_rise),
    .show_rise   (show_rise),
    .pix_last    (pix_last),
    .st_ready    (st_ready),
    .live_rd_data(live_rd_data),
    .st_rdata    (st_rdata),
    .live_rd_en  (live_rd_en),
    .live_freeze (live_freeze),
    .st_req      (st_req),
    .st_we       (st_we),
    .st_wdata    (st_wdata),
    .snap_wr_en  (snap_wr_en),
    .snap_wr_data(snap_wr_data),
    .pix_step    (pix_step),
    .take_done   (take_done),
    .show_done   (show_done)
  );

  assign live_rd_addr = pix_addr;
  assign st_addr      = pix_addr;
  assign snap_wr_addr = pix_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) disp_sel <= 1'b0;
    else        disp_sel <= btn_show;
  end

endmodule

// File: rtl/snapcap_chk.sv
module snapcap_chk #(
  parameter int NPIX  = 76800,
  parameter int AW    = 17,
  parameter int PIX_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             btn_show,
  input logic             disp_sel,
  input logic             st_req,
  input logic             st_we,
  input logic             st_ready,
  input logic [AW-1:0]    st_addr,
  input logic [PIX_W-1:0] st_wdata,
  input logic             live_freeze,
  input logic             snap_wr_en,
  input logic             take_done,
  input logic             show_done,
  input logic             pix_step,
  input logic             pix_last
);

  localparam logic [AW-1:0] LAST_ADDR = AW'(NPIX - 1);

  assert_sel_on_R2: assert property (@(posedge clk) disable iff (!rst_n)
    btn_show |=> disp_sel);
  assert_sel_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !btn_show |=> !disp_sel);

  assert_addr_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    st_req |-> st_addr <= LAST_ADDR);
  assert_raster_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_step && !pix_last) |=> st_addr == $past(st_addr) + 1'b1);

  assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_req && !st_ready) |=> st_req && $stable(st_addr) && $stable(st_we)
                              && (!st_we || $stable(st_wdata)));

  assert_done_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_step && pix_last) |=> (take_done || show_done));
  assert_take_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    take_done |=> !take_done);
  assert_show_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    show_done |=> !show_done);
  assert_done_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({take_done, show_done}));

  assert_freeze_on_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_req && st_we) |-> live_freeze);
  assert_no_freeze_on_show_R7: assert property (@(posedge clk) disable iff (!rst_n)
    snap_wr_en |-> !live_freeze);

endmodule

bind snapcap_ctrl snapcap_chk #(.NPIX(NPIX), .AW(AW), .PIX_W(PIX_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .btn_show   (btn_show),
  .disp_sel   (disp_sel),
  .st_req     (st_req),
  .st_we      (st_we),
  .st_ready   (st_ready),
  .st_addr    (st_addr),
  .st_wdata   (st_wdata),
  .live_freeze(live_freeze),
  .snap_wr_en (snap_wr_en),
  .take_done  (take_done),
  .show_done  (show_done),
  .pix_step   (pix_step),
  .pix_last   (pix_last)
);

// File: tb/tb_snapcap_ctrl.sv
`timescale 1ns/1ps
module tb_snapcap_ctrl;

  localparam int H    = 16;
  localparam int V    = 8;
  localparam int PW   = 16;
  localparam int NPIX = H * V;
  localparam int AW   = $clog2(NPIX);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic btn_take = 1'b0, btn_show = 1'b0;
  logic live_rd_en, live_freeze, st_req, st_we, snap_wr_en, disp_sel, take_done, show_done;
  logic [AW-1:0] live_rd_addr, st_addr, snap_wr_addr;
  logic [PW-1:0] live_rd_data = '0, st_rdata = '0, st_wdata, snap_wr_data;
  logic st_ready = 1'b0;

  always #4 clk = ~clk;

  snapcap_ctrl #(.H_PIX(H), .V_PIX(V), .PIX_W(PW)) dut (
    .clk(clk), .rst_n(rst_n), .btn_take(btn_take), .btn_show(btn_show),
    .live_rd_en(live_rd_en), .live_rd_addr(live_rd_addr), .live_rd_data(live_rd_data),
    .live_freeze(live_freeze), .st_req(st_req), .st_we(st_we), .st_addr(st_addr),
    .st_wdata(st_wdata), .st_ready(st_ready), .st_rdata(st_rdata),
    .snap_wr_en(snap_wr_en), .snap_wr_addr(snap_wr_addr), .snap_wr_data(snap_wr_data),
    .disp_sel(disp_sel), .take_done(take_done), .show_done(show_done)
  );

  // Memory models
  logic [PW-1:0] live_mem  [NPIX];
  logic [PW-1:0] store_mem [NPIX];
  logic [PW-1:0] snap_mem  [NPIX];
  logic          cam_on = 1'b0;
  logic [AW-1:0] cam_addr = '0;
  int            ready_pct = 100;

  always @(posedge clk) begin
    if (live_rd_en) live_rd_data <= live_mem[live_rd_addr];
    if (cam_on && !live_freeze) begin
      live_mem[cam_addr] <= PW'($urandom);
      cam_addr <= (cam_addr == AW'(NPIX - 1)) ? '0 : cam_addr + 1'b1;
    end
  end

  always @(posedge clk) begin
    if (st_req && st_ready) begin
      if (st_we) store_mem[st_addr] <= st_wdata;
      else       st_rdata <= store_mem[st_addr];
    end
    if (snap_wr_en) snap_mem[snap_wr_addr] <= snap_wr_data;
  end

  // Monitors
  int take_done_cnt = 0, show_done_cnt = 0, snap_wr_cnt = 0, st_wr_cnt = 0;
  int hold_viol = 0, freeze_viol = 0;
  logic          p_req = 1'b0, p_rdy = 1'b0, p_we = 1'b0;
  logic [AW-1:0] p_addr = '0;
  logic [PW-1:0] p_wdata = '0;

  always @(posedge clk) begin
    if (rst_n) begin
      if (take_done) take_done_cnt <= take_done_cnt + 1;
      if (show_done) show_done_cnt <= show_done_cnt + 1;
      if (snap_wr_en) snap_wr_cnt <= snap_wr_cnt + 1;
      if (st_req && st_we && st_ready) st_wr_cnt <= st_wr_cnt + 1;
      if (st_req && st_we && !live_freeze) freeze_viol <= freeze_viol + 1;
      if (snap_wr_en && live_freeze) freeze_viol <= freeze_viol + 1;
      if (p_req && !p_rdy &&
          !(st_req && st_addr == p_addr && st_we == p_we && (!p_we || st_wdata == p_wdata)))
        hold_viol <= hold_viol + 1;
      p_req <= st_req; p_rdy <= st_ready; p_we <= st_we;
      p_addr <= st_addr; p_wdata <= st_wdata;
    end
  end

  // Checking
  int checks = 0, failures = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Expected select: the button level one edge earlier.
  function automatic logic exp_sel(input logic prev_btn);
    return prev_btn;
  endfunction

  function automatic int frame_mismatch_live();
    int n = 0;
    for (int i = 0; i < NPIX; i++) if (store_mem[i] !== live_mem[i]) n++;
    return n;
  endfunction

  function automatic int frame_mismatch_snap();
    int n = 0;
    for (int i = 0; i < NPIX; i++) if (snap_mem[i] !== store_mem[i]) n++;
    return n;
  endfunction

  task automatic wait_take();
    while (!take_done) @(negedge clk);
  endtask

  task automatic wait_show();
    while (!show_done) @(negedge clk);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      st_ready = (($urandom % 100) < ready_pct);
    end
  end

  task automatic run_all();
    int t0, s0, w0, sw0;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(!st_req && !live_rd_en && !snap_wr_en, "R1", "strobes in reset", st_req, 0);
    chk(!live_freeze && !disp_sel, "R1", "freeze/sel in reset", live_freeze, 0);
    chk(!take_done && !show_done, "R1", "done in reset", take_done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!st_req && !live_freeze && !disp_sel && !take_done, "R1", "first cycle after reset", st_req, 0);
    cam_on = 1'b1;
    repeat (NPIX + 4) @(negedge clk);

    for (int r = 0; r < 4; r++) begin
      ready_pct = (r == 0) ? 100 : (r == 1) ? 15 : 40 + 15 * r;
      t0 = take_done_cnt;
      btn_take = 1'b1;
      @(negedge clk);
      btn_take = 1'b0;
      chk(live_freeze, "R7", "freeze after capture press", live_freeze, 1);
      wait_take();
      chk(frame_mismatch_live() == 0, "R3", "store vs live frame", frame_mismatch_live(), 0);
      @(negedge clk);
      chk(!take_done && take_done_cnt == t0 + 1, "R6", "one take pulse", take_done_cnt - t0, 1);
      chk(!live_freeze, "R7", "freeze low after capture", live_freeze, 0);

      s0 = show_done_cnt;
      btn_show = 1'b1;
      @(negedge clk);
      chk(disp_sel == exp_sel(1'b1), "R2", "select while held", disp_sel, 1);
      chk(!live_freeze, "R7", "no freeze during show", live_freeze, 0);
      wait_show();
      chk(frame_mismatch_snap() == 0, "R5", "snapshot vs store frame", frame_mismatch_snap(), 0);
      @(negedge clk);
      chk(!show_done && show_done_cnt == s0 + 1, "R6", "one show pulse", show_done_cnt - s0, 1);
      chk(disp_sel == exp_sel(1'b1), "R2", "select still held", disp_sel, 1);
      btn_show = 1'b0;
      @(negedge clk);
      chk(disp_sel == exp_sel(1'b0), "R2", "select after release", disp_sel, 0);
      repeat (NPIX / 2) @(negedge clk);
    end

    // R8: show edge during capture dropped; held capture level does not restart
    ready_pct = 50;
    t0 = take_done_cnt; s0 = show_done_cnt; w0 = snap_wr_cnt;
    btn_take = 1'b1;
    repeat (6) @(negedge clk);
    btn_show = 1'b1;
    @(negedge clk);
    btn_show = 1'b0;
    wait_take();
    sw0 = st_wr_cnt;
    repeat (40) @(negedge clk);
    chk(show_done_cnt == s0 && snap_wr_cnt == w0, "R8", "show edge while busy", snap_wr_cnt - w0, 0);
    chk(st_wr_cnt == sw0 && !live_freeze, "R8", "held capture level no restart", st_wr_cnt - sw0, 0);
    chk(take_done_cnt == t0 + 1, "R8", "single capture", take_done_cnt - t0, 1);
    btn_take = 1'b0;
    @(negedge clk);

    // R9: simultaneous edges while idle
    t0 = take_done_cnt; s0 = show_done_cnt; w0 = snap_wr_cnt;
    btn_take = 1'b1; btn_show = 1'b1;
    @(negedge clk);
    btn_take = 1'b0;
    chk(live_freeze, "R9", "capture wins", live_freeze, 1);
    wait_take();
    chk(frame_mismatch_live() == 0, "R9", "store after simultaneous press", frame_mismatch_live(), 0);
    repeat (40) @(negedge clk);
    chk(show_done_cnt == s0 && snap_wr_cnt == w0, "R9", "show edge dropped", snap_wr_cnt - w0, 0);
    btn_show = 1'b0;
    @(negedge clk);

    chk(hold_viol == 0, "R4", "request held until ready", hold_viol, 0);
    chk(freeze_viol == 0, "R7", "freeze covers capture only", freeze_viol, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule